// File: doc/BRIEF.md
# Sector Erase Batching Timer

This block gathers sector-erase requests into one erase batch. A sector-erase command arriving while the block is idle opens an acceptance window of a fixed number of clock cycles and sets the matching bit in a one-bit-per-sector mask. Each further sector-erase command that lands inside the open window adds its sector to the mask and restarts the full window. When the window runs out without a new sector, the batch closes. The status bit `dq3` rises, an `erase_start` pulse is given and the erase engine starts on the collected mask.

While a batch is being erased, `dq3` stays high and every command is turned away except a suspend. A suspend freezes the engine and keeps the mask. A resume then continues the same batch. The engine is modelled as a fixed number of cycles per selected sector. When it finishes, the mask clears, `dq3` falls and `erase_done` pulses. A chip-erase command given while idle skips the window entirely and erases every sector at once.

Every command strobe gets a one-cycle `cmd_accept` or `cmd_reject` answer in the cycle after it is sampled. This lets the host see when a command did not take effect.

Top module: `sector_erase_batcher`

## Requirements
- R1: After reset, `sect_mask` is 0, `dq3` is 0, `erase_busy` and `suspended` are 0, and no pulse output is high.
- R2: The sector index is the upper `SEC_W` bits of `cmd_addr`, above `OFS_W` offset bits that are ignored. A sector-erase command accepted while idle sets only that sector's bit in `sect_mask`, pulses `cmd_accept` and leaves `dq3` at 0.
- R3: `dq3` rises, and `erase_start` pulses, exactly `WINDOW_CYC` cycles after the clock edge that accepted the last sector-erase command of the batch.
- R4: A sector-erase command sampled while the window is open, and not on its final cycle, is accepted. It ORs its sector into the mask, including a sector that is already set, and restarts the full window.
- R5: A sector-erase command sampled on the final cycle of the window is rejected, and the mask is left unchanged.
- R6: While `dq3` is 1, sector-erase, chip-erase, other and unmatched resume commands are rejected, and `sect_mask` does not change until the erase finishes.
- R7: A chip-erase command accepted while idle sets all mask bits. It raises `dq3` and pulses `erase_start` in the next cycle, with no window.
- R8: An erase keeps `erase_busy` high for exactly (number of set mask bits) × `ERASE_CYC` cycles. After that, `sect_mask` and `dq3` return to 0 and `erase_done` pulses.
- R9: A suspend during an erase is accepted. It raises `suspended`, keeps the mask and `dq3`, and stops the erase progress. A resume is accepted and continues the same erase, so the total number of busy cycles is unchanged.
- R10: During the window, chip-erase, suspend, resume and other commands are rejected and do not restart the window. While idle, suspend and resume are rejected and other commands are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_sector | input | 1 | Sector-erase command strobe |
| cmd_chip | input | 1 | Chip-erase command strobe |
| cmd_suspend | input | 1 | Erase-suspend command strobe |
| cmd_resume | input | 1 | Erase-resume command strobe |
| cmd_other | input | 1 | Any other decoded command |
| cmd_addr | input | OFS_W+SEC_W | Word address that comes with a sector-erase command |
| sect_mask | output | SECTORS | Collected sectors, one bit each |
| dq3 | output | 1 | 0 while the batch may still grow or idle, 1 while the batch is closed and erasing |
| erase_start | output | 1 | One-cycle pulse when the erase engine starts |
| erase_busy | output | 1 | Erase engine running (not suspended) |
| erase_done | output | 1 | One-cycle pulse when the erase completes |
| suspended | output | 1 | Erase paused by a suspend |
| cmd_accept | output | 1 | Previous cycle's command was accepted |
| cmd_reject | output | 1 | Previous cycle's command was rejected |

## Verification
The assertions assume the command decoder raises at most one command strobe in any cycle, so that accept and reject never compete for the same cycle. The bench drives every command as a single-cycle strobe set and cleared on falling edges, one kind at a time. It places the strobes a counted number of cycles after the accepting edge, so that the window's last cycle, the cycle before it and the erase-finish cycle are each reached on purpose.

// File: rtl/sector_erase_batcher.sv
module sector_erase_batcher #(
  parameter int SECTORS    = 16,
  parameter int OFS_W      = 16,
  parameter int WINDOW_CYC = 40,
  parameter int ERASE_CYC  = 12,
  localparam int SEC_W     = $clog2(SECTORS),
  localparam int ADDR_W    = OFS_W + SEC_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_sector,
  input  logic               cmd_chip,
  input  logic               cmd_suspend,
  input  logic               cmd_resume,
  input  logic               cmd_other,
  input  logic [ADDR_W-1:0]  cmd_addr,
  output logic [SECTORS-1:0] sect_mask,
  output logic               dq3,
  output logic               erase_start,
  output logic               erase_busy,
  output logic               erase_done,
  output logic               suspended,
  output logic               cmd_accept,
  output logic               cmd_reject
);
  localparam int WIN_W  = $clog2(WINDOW_CYC + 1);
  localparam int ECNT_W = $clog2(SECTORS * ERASE_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_WIN, ST_ERASE, ST_SUSP} state_t;

  state_t              st;
  logic [WIN_W-1:0]    win_cnt;
  logic [ECNT_W-1:0]   ecnt;
  logic [SEC_W-1:0]    sec_idx;
  logic [SECTORS-1:0]  sec_bit;
  logic                win_expire, erase_last, any_cmd, accept_now;

  function automatic logic [ECNT_W-1:0] batch_cycles(input logic [SECTORS-1:0] m);
    logic [ECNT_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < SECTORS; i++)
      if (m[i]) acc = acc + ECNT_W'(ERASE_CYC);
    return acc;
  endfunction

  assign sec_idx    = cmd_addr[ADDR_W-1:OFS_W];
  assign sec_bit    = {{(SECTORS-1){1'b0}}, 1'b1} << sec_idx;
  assign win_expire = (st == ST_WIN) && (win_cnt == WIN_W'(1));
  assign erase_last = (st == ST_ERASE) && (ecnt == ECNT_W'(1));
  assign any_cmd    = cmd_sector | cmd_chip | cmd_suspend | cmd_resume | cmd_other;
  assign erase_busy = (st == ST_ERASE);
  assign suspended  = (st == ST_SUSP);

  always_comb begin
    case (st)
      ST_IDLE:  accept_now = cmd_sector | cmd_chip | cmd_other;
      ST_WIN:   accept_now = cmd_sector & ~win_expire;
      ST_ERASE: accept_now = cmd_suspend & ~erase_last;
      default:  accept_now = cmd_resume;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      sect_mask   <= '0;
      win_cnt     <= '0;
      ecnt        <= '0;
      dq3         <= 1'b0;
      erase_start <= 1'b0;
      erase_done  <= 1'b0;
      cmd_accept  <= 1'b0;
      cmd_reject  <= 1'b0;
    end else begin
      erase_start <= 1'b0;
      erase_done  <= 1'b0;
      cmd_accept  <= any_cmd & accept_now;
      cmd_reject  <= any_cmd & ~accept_now;
      case (st)
        ST_IDLE: begin
          if (cmd_sector) begin
            sect_mask <= sec_bit;
            win_cnt   <= WIN_W'(WINDOW_CYC);
            st        <= ST_WIN;
          end else if (cmd_chip) begin
            sect_mask   <= '1;
            ecnt        <= ECNT_W'(SECTORS * ERASE_CYC);
            dq3         <= 1'b1;
            erase_start <= 1'b1;
            st          <= ST_ERASE;
          end
        end
        ST_WIN: begin
          if (win_expire) begin
            ecnt        <= batch_cycles(sect_mask);
            dq3         <= 1'b1;
            erase_start <= 1'b1;
            st          <= ST_ERASE;
          end else if (cmd_sector) begin
            sect_mask <= sect_mask | sec_bit;
            win_cnt   <= WIN_W'(WINDOW_CYC);
          end else begin
            win_cnt <= win_cnt - WIN_W'(1);
          end
        end
        ST_ERASE: begin
          if (erase_last) begin
            sect_mask  <= '0;
            ecnt       <= '0;
            dq3        <= 1'b0;
            erase_done <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            ecnt <= ecnt - ECNT_W'(1);
            if (cmd_suspend) st <= ST_SUSP;
          end
        end
        default: begin
          if (cmd_resume) st <= ST_ERASE;
        end
      endcase
    end
  end

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_sector, cmd_chip, cmd_suspend, cmd_resume, cmd_other})); // R10
  AST_ACC_XOR_REJ: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_accept && cmd_reject)); // R5
  AST_RISE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq3) |-> erase_start); // R3
  AST_MASK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (dq3 && $past(dq3)) |-> $stable(sect_mask)); // R6
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    erase_done |-> (sect_mask == '0 && !dq3 && !erase_busy)); // R8
  AST_SUSP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended && $past(suspended)) |-> ($stable(ecnt) && dq3)); // R9
  AST_WIN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WIN) |-> (!dq3 && sect_mask != '0)); // R4
endmodule

// File: tb/test_sector_erase_batcher.sv
module test_sector_erase_batcher;
  localparam int SECTORS = 16, OFS_W = 16, WIN = 40, EC = 12;
  localparam int AW = OFS_W + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_sector = 0, cmd_chip = 0, cmd_suspend = 0, cmd_resume = 0, cmd_other = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic [SECTORS-1:0] sect_mask;
  logic dq3, erase_start, erase_busy, erase_done, suspended, cmd_accept, cmd_reject;

  int checks = 0, errors = 0, busy_cnt = 0;

  sector_erase_batcher #(.SECTORS(SECTORS), .OFS_W(OFS_W), .WINDOW_CYC(WIN), .ERASE_CYC(EC))
  i_sector_erase_batcher (.*);

  always #10 clk = ~clk;
  always @(negedge clk) if (erase_busy) busy_cnt++;

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  typedef enum {K_SEC, K_CHIP, K_SUSP, K_RES, K_OTH} kind_t;

  task automatic issue(input kind_t k, input logic [3:0] sec, input logic [15:0] ofs);
    @(negedge clk);
    cmd_addr = {sec, ofs};
    cmd_sector = (k == K_SEC); cmd_chip = (k == K_CHIP); cmd_suspend = (k == K_SUSP);
    cmd_resume = (k == K_RES); cmd_other = (k == K_OTH);
    @(negedge clk);
    {cmd_sector, cmd_chip, cmd_suspend, cmd_resume, cmd_other} = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_erase(input string req, input int exp_busy);
    for (int i = 0; i < 1000 && !erase_done; i++) @(negedge clk);
    chk({req, " done pulse"}, erase_done, 1);
    chk({req, " busy cycles"}, busy_cnt, exp_busy);
    chk({req, " mask cleared"}, sect_mask, 0);
    chk({req, " dq3 low"}, dq3, 0);
  endtask

  task automatic t_reset();
    chk("R1 mask", sect_mask, 0);
    chk("R1 dq3", dq3, 0);
    chk("R1 flags", {erase_busy, suspended, erase_start, erase_done, cmd_accept, cmd_reject}, 0);
  endtask

  task automatic t_single();
    issue(K_SEC, 4'd5, 16'hBEEF);
    chk("R2 accept", {cmd_accept, cmd_reject}, 2'b10);
    chk("R2 mask bit", sect_mask, 16'h0020);
    chk("R2 dq3 low", dq3, 0);
    idle(WIN - 1);
    chk("R3 dq3 before expiry", dq3, 0);
    busy_cnt = 0;
    idle(1);
    chk("R3 dq3 rise", dq3, 1);
    chk("R3 erase_start", erase_start, 1);
    finish_erase("R8 single", EC);
  endtask

  task automatic t_restart();
    issue(K_SEC, 4'd1, 16'h0000);
    idle(WIN - 3);
    issue(K_SEC, 4'd9, 16'hFFFF);
    chk("R4 accept", cmd_accept, 1);
    chk("R4 mask or", sect_mask, 16'h0202);
    idle(WIN - 3);
    issue(K_SEC, 4'd9, 16'h1234);
    chk("R4 same sector accepted", cmd_accept, 1);
    chk("R4 mask same", sect_mask, 16'h0202);
    idle(WIN - 1);
    chk("R4 window restarted", dq3, 0);
    busy_cnt = 0;
    idle(1);
    chk("R4 dq3 rise after restart", dq3, 1);
    finish_erase("R8 two sectors", 2 * EC);
  endtask

  task automatic t_expiry_edge();
    issue(K_SEC, 4'd3, 16'h0042);
    idle(WIN - 2);
    busy_cnt = 0;
    issue(K_SEC, 4'd7, 16'h0042);
    chk("R5 reject", {cmd_accept, cmd_reject}, 2'b01);
    chk("R5 mask unchanged", sect_mask, 16'h0008);
    chk("R5 dq3 rise", dq3, 1);
    finish_erase("R8 after late cmd", EC);
  endtask

  task automatic t_busy_ignore();
    issue(K_SEC, 4'd0, 16'h0);
    issue(K_SEC, 4'd15, 16'h0);
    issue(K_SEC, 4'd8, 16'h0);
    idle(WIN - 1);
    busy_cnt = 0;
    idle(1);
    chk("R6 dq3", dq3, 1);
    issue(K_SEC, 4'd2, 16'h0);
    chk("R6 sector rejected", cmd_reject, 1);
    issue(K_CHIP, 4'd0, 16'h0);
    chk("R6 chip rejected", cmd_reject, 1);
    issue(K_OTH, 4'd0, 16'h0);
    chk("R6 other rejected", cmd_reject, 1);
    issue(K_RES, 4'd0, 16'h0);
    chk("R6 resume rejected", cmd_reject, 1);
    chk("R6 mask held", sect_mask, 16'h8101);
    finish_erase("R8 three sectors", 3 * EC);
  endtask

  task automatic t_suspend();
    issue(K_SEC, 4'd4, 16'h0);
    issue(K_SEC, 4'd6, 16'h0);
    idle(WIN - 1);
    busy_cnt = 0;
    idle(1);
    idle(5);
    issue(K_SUSP, 4'd0, 16'h0);
    chk("R9 suspend accepted", cmd_accept, 1);
    chk("R9 suspended", {suspended, erase_busy, dq3}, 3'b101);
    idle(30);
    chk("R9 no finish while paused", {erase_done, dq3, suspended}, 3'b011);
    chk("R9 mask kept", sect_mask, 16'h0050);
    issue(K_SEC, 4'd1, 16'h0);
    chk("R9 sector rejected in suspend", cmd_reject, 1);
    issue(K_RES, 4'd0, 16'h0);
    chk("R9 resume accepted", cmd_accept, 1);
    chk("R9 running again", {suspended, erase_busy}, 2'b01);
    finish_erase("R9 total busy", 2 * EC);
  endtask

  task automatic t_chip();
    busy_cnt = 0;
    issue(K_CHIP, 4'd0, 16'h0);
    chk("R7 accept", cmd_accept, 1);
    chk("R7 dq3 immediate", dq3, 1);
    chk("R7 start", erase_start, 1);
    chk("R7 all sectors", sect_mask, 16'hFFFF);
    finish_erase("R8 chip", SECTORS * EC);
  endtask

  task automatic t_window_others();
    issue(K_SUSP, 4'd0, 16'h0);
    chk("R10 idle suspend rejected", cmd_reject, 1);
    issue(K_RES, 4'd0, 16'h0);
    chk("R10 idle resume rejected", cmd_reject, 1);
    issue(K_OTH, 4'd0, 16'h0);
    chk("R10 idle other accepted", cmd_accept, 1);
    chk("R10 idle state", {dq3, sect_mask}, 0);
    issue(K_SEC, 4'd10, 16'h0);
    idle(10);
    issue(K_CHIP, 4'd0, 16'h0);
    chk("R10 chip in window rejected", cmd_reject, 1);
    issue(K_OTH, 4'd0, 16'h0);
    chk("R10 other in window rejected", cmd_reject, 1);
    issue(K_SUSP, 4'd0, 16'h0);
    chk("R10 suspend in window rejected", cmd_reject, 1);
    chk("R10 mask", sect_mask, 16'h0400);
    idle(WIN - 17);
    chk("R10 window not restarted (before)", dq3, 0);
    busy_cnt = 0;
    idle(1);
    chk("R10 window not restarted (rise)", dq3, 1);
    finish_erase("R8 after window noise", EC);
  endtask

  initial begin
    idle(3);
    t_reset();
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_single();
    t_restart();
    t_expiry_edge();
    t_busy_ignore();
    t_suspend();
    t_chip();
    t_window_others();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule